// File: doc/BRIEF.md
# Retransmit FIFO with Half-Full Flag

This block is a first-in first-out queue for 9-bit words, sized for a byte plus one framing or parity bit. Words go into a dual-port store at a write address counter and come out at a read address counter. Both counters run on one system clock. The write and read strobes are active low and are sampled on each rising edge. A read and a write may be accepted in the same edge.

Three status flags come straight from the occupancy, which is the write pointer minus the read pointer. Empty means nothing is stored. Full means the store holds `DEPTH` words. Half means more than half of the store is in use. A rewind input moves only the read pointer back to the first word stored since reset, so a message that has already been read can be read out again. The write pointer does not move.

`DEPTH` must be a power of two. Rewind gives the intended result only while no more than `DEPTH` words have been written since reset.

Top module: `fifo9_rt`

## Requirements
- R1: While `rst` is high at a rising edge, both pointers and the output word are cleared. After that edge `empty` is 1, `full` is 0, `half` is 0 and `dout` is 0.
- R2: A low `wr_n` at an edge where `full` is 0 stores `din`. A low `rd_n` at an edge where `empty` is 0 and `rewind` is 0 puts the oldest stored word on `dout` after that edge. Words leave in the order they were written.
- R3: `empty` is 1 exactly when the occupancy is 0. `full` is 1 exactly when the occupancy equals `DEPTH`. The two are never 1 together.
- R4: `half` is 1 exactly when the occupancy is greater than `DEPTH/2`. With `DEPTH` = 8 this means 5 or more words.
- R5: A write strobe at an edge where `full` is 1 is dropped. The flags stay as they were, and the dropped word is never read out.
- R6: A read strobe at an edge where `empty` is 1 is dropped and `dout` holds its value. A write at the same edge is still accepted.
- R7: When the block is neither empty nor full and both strobes are low at one edge, both operations take place and the occupancy does not change.
- R8: `rewind` high at an edge returns the read pointer to the first word written since reset and leaves the write pointer as it was. A read strobe at the same edge is dropped and `dout` holds. The flags after that edge follow the new occupancy, and the next read returns that first word again.
- R9: The pointers wrap at the end of the store. One extra pointer bit tells a full store from an empty one when the two addresses are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| din | input | WIDTH | Word to store |
| rd_n | input | 1 | Read strobe, active low |
| rewind | input | 1 | Return read pointer to the first word, active high |
| dout | output | WIDTH | Last word read out |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals DEPTH |
| half | output | 1 | Occupancy exceeds DEPTH/2 |

## Verification
The bench builds the block with `DEPTH` = 8 and `WIDTH` = 9. At that depth a few dozen edges are enough to reach the half and full thresholds and to drop writes against a full store. The same short run wraps the address counters, so full and empty are both seen at equal addresses. A rewind issued after exactly eight writes, with every word already read, brings the block back to full. This case is out of reach at the default depth within a short run.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

    // Status flags decoded from the occupancy
    typedef struct packed {
        logic empty;
        logic full;
        logic half;
    } flags_t;

    // Accepted operation at one clock edge
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_WR   = 2'b01,
        OP_RD   = 2'b10,
        OP_BOTH = 2'b11
    } op_e;

    function automatic op_e decode_op(input logic wr_ok, input logic rd_ok);
        case ({rd_ok, wr_ok})
            2'b01:   return OP_WR;
            2'b10:   return OP_RD;
            2'b11:   return OP_BOTH;
            default: return OP_IDLE;
        endcase
    endfunction

    function automatic logic op_writes(input op_e op);
        return (op == OP_WR) || (op == OP_BOTH);
    endfunction

    function automatic logic op_reads(input op_e op);
        return (op == OP_RD) || (op == OP_BOTH);
    endfunction

endpackage

// File: rtl/fifo9_ptr.sv
module fifo9_ptr #(
    parameter int PW         = 12,
    parameter bit REWINDABLE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          rewind,
    output logic [PW-1:0] ptr
);

    // Pointer with one wrap bit above the address bits
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (REWINDABLE && rewind) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/fifo9_mem.sv
module fifo9_mem #(
    parameter int AW    = 11,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    localparam int WORDS = 1 << AW;

    logic [WIDTH-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Registered read port; holds when no read is accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/fifo9_status.sv
module fifo9_status
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int PW    = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wptr,
    input  logic [PW-1:0] rptr,
    output logic [PW-1:0] level,
    output flags_t        flags
);

    localparam logic [PW-1:0] LVL_FULL = PW'(DEPTH);
    localparam logic [PW-1:0] LVL_HALF = PW'(DEPTH / 2);

    assign level       = wptr - rptr;
    assign flags.empty = (level == '0);
    assign flags.full  = (level == LVL_FULL);
    assign flags.half  = (level > LVL_HALF);

    // R9: occupancy never runs beyond the store size
    a_r9_level_bounded: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_FULL);

    // R3: a store cannot be empty and full together
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flags.empty && flags.full));

    // R4: more than half in use implies something is stored
    a_r4_half_not_empty: assert property (@(posedge clk) disable iff (rst)
        flags.half |-> !flags.empty);

endmodule

// File: rtl/fifo9_rt.sv
module fifo9_rt
    import fifo9_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_n,
    input  logic             rewind,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             half
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [PW-1:0] level;
    flags_t        fl;
    op_e           op;
    logic          wr_ok;
    logic          rd_ok;

    // A full store drops writes; an empty store or a rewind drops reads
    assign wr_ok = !wr_n && !fl.full;
    assign rd_ok = !rd_n && !fl.empty && !rewind;
    assign op    = decode_op(wr_ok, rd_ok);

    fifo9_ptr #(.PW(PW), .REWINDABLE(1'b0)) i_wptr (
        .clk    (clk),
        .rst    (rst),
        .step   (op_writes(op)),
        .rewind (1'b0),
        .ptr    (wptr)
    );

    fifo9_ptr #(.PW(PW), .REWINDABLE(1'b1)) i_rptr (
        .clk    (clk),
        .rst    (rst),
        .step   (op_reads(op)),
        .rewind (rewind),
        .ptr    (rptr)
    );

    fifo9_mem #(.AW(AW), .WIDTH(WIDTH)) i_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (op_writes(op)),
        .waddr (wptr[AW-1:0]),
        .wdata (din),
        .re    (op_reads(op)),
        .raddr (rptr[AW-1:0]),
        .rdata (dout)
    );

    fifo9_status #(.DEPTH(DEPTH), .PW(PW)) i_status (
        .clk   (clk),
        .rst   (rst),
        .wptr  (wptr),
        .rptr  (rptr),
        .level (level),
        .flags (fl)
    );

    assign empty = fl.empty;
    assign full  = fl.full;
    assign half  = fl.half;

    // R1: reset leaves an empty store
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (empty && !full && !half && dout == '0));

    // R5: a write against a full store does not move the write pointer
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && !wr_n) |=> $stable(wptr));

    // R6: a read against an empty store leaves the output word alone
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (empty && !rd_n) |=> $stable(dout));

    // R7: a paired read and write keep the occupancy
    a_r7_pair_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !rd_n && !rewind && !empty && !full) |=> $stable(level));

    // R8: rewind sends the read pointer to the start and holds the output
    a_r8_rewind_start: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (rptr == '0 && $stable(dout)));

endmodule

// File: tb/test_fifo9_rt.sv
`timescale 1ns/1ps
module test_fifo9_rt;

    localparam int DEPTH = 8;
    localparam int WIDTH = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_n = 1'b1;
    logic             rd_n = 1'b1;
    logic             rewind = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic             empty;
    logic             full;
    logic             half;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fifo9_rt #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_fifo9_rt (
        .clk    (clk),
        .rst    (rst),
        .wr_n   (wr_n),
        .din    (din),
        .rd_n   (rd_n),
        .rewind (rewind),
        .dout   (dout),
        .empty  (empty),
        .full   (full),
        .half   (half)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wn;
        logic        rn;
        logic [8:0]  d;
        logic [8:0]  q;
        logic        e;
        logic        f;
        logic        h;
    } vec_t;

    // Each entry: tag, wr_n, rd_n, din, then dout/empty/full/half after the edge
    localparam vec_t VECS [24] = '{
        '{4'd6, 1'b1, 1'b0, 9'h000, 9'h000, 1'b1, 1'b0, 1'b0}, // R6 read while empty
        '{4'd2, 1'b0, 1'b1, 9'h101, 9'h000, 1'b0, 1'b0, 1'b0}, // R2
        '{4'd2, 1'b0, 1'b1, 9'h102, 9'h000, 1'b0, 1'b0, 1'b0},
        '{4'd2, 1'b0, 1'b1, 9'h103, 9'h000, 1'b0, 1'b0, 1'b0},
        '{4'd4, 1'b0, 1'b1, 9'h104, 9'h000, 1'b0, 1'b0, 1'b0}, // R4 four words
        '{4'd4, 1'b0, 1'b1, 9'h105, 9'h000, 1'b0, 1'b0, 1'b1}, // R4 five words
        '{4'd2, 1'b1, 1'b0, 9'h000, 9'h101, 1'b0, 1'b0, 1'b0}, // R2 oldest first
        '{4'd7, 1'b0, 1'b0, 9'h106, 9'h102, 1'b0, 1'b0, 1'b0}, // R7 paired
        '{4'd4, 1'b0, 1'b1, 9'h107, 9'h102, 1'b0, 1'b0, 1'b1},
        '{4'd4, 1'b0, 1'b1, 9'h108, 9'h102, 1'b0, 1'b0, 1'b1},
        '{4'd9, 1'b0, 1'b1, 9'h109, 9'h102, 1'b0, 1'b0, 1'b1}, // R9 wrapped address
        '{4'd3, 1'b0, 1'b1, 9'h10A, 9'h102, 1'b0, 1'b1, 1'b1}, // R3 full
        '{4'd5, 1'b0, 1'b1, 9'h1FF, 9'h102, 1'b0, 1'b1, 1'b1}, // R5 dropped write
        '{4'd2, 1'b1, 1'b0, 9'h000, 9'h103, 1'b0, 1'b0, 1'b1},
        '{4'd2, 1'b1, 1'b0, 9'h000, 9'h104, 1'b0, 1'b0, 1'b1},
        '{4'd4, 1'b1, 1'b0, 9'h000, 9'h105, 1'b0, 1'b0, 1'b1},
        '{4'd4, 1'b1, 1'b0, 9'h000, 9'h106, 1'b0, 1'b0, 1'b0},
        '{4'd2, 1'b1, 1'b0, 9'h000, 9'h107, 1'b0, 1'b0, 1'b0},
        '{4'd9, 1'b1, 1'b0, 9'h000, 9'h108, 1'b0, 1'b0, 1'b0},
        '{4'd9, 1'b1, 1'b0, 9'h000, 9'h109, 1'b0, 1'b0, 1'b0},
        '{4'd5, 1'b1, 1'b0, 9'h000, 9'h10A, 1'b1, 1'b0, 1'b0}, // R5 0x1FF never out
        '{4'd6, 1'b1, 1'b0, 9'h000, 9'h10A, 1'b1, 1'b0, 1'b0}, // R6 hold
        '{4'd6, 1'b0, 1'b0, 9'h10B, 9'h10A, 1'b0, 1'b0, 1'b0}, // R6 write still taken
        '{4'd2, 1'b1, 1'b0, 9'h000, 9'h10B, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [WIDTH+2:0] act,
                         input logic [WIDTH+2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {dout,empty,full,half} actual %h expected %h",
                     tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, return at the next falling edge
    task automatic cycle(input logic wn, input logic rn, input logic rw,
                         input logic [WIDTH-1:0] d);
        wr_n = wn; rd_n = rn; rewind = rw; din = d;
        @(posedge clk);
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; rewind = 1'b0; din = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset state", {dout, empty, full, half}, {9'h000, 3'b100});

        foreach (VECS[i]) begin
            cycle(VECS[i].wn, VECS[i].rn, 1'b0, VECS[i].d);
            check($sformatf("R%0d vector %0d", VECS[i].req, i),
                  {dout, empty, full, half},
                  {VECS[i].q, VECS[i].e, VECS[i].f, VECS[i].h});
        end

        // R8 partial rewind, with a read strobe on the rewind edge
        do_reset();
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b1, 1'b0, 9'h0A1 + 9'(k));
        cycle(1'b1, 1'b0, 1'b0, '0);
        cycle(1'b1, 1'b0, 1'b0, '0);
        check("R2 second read", {dout, empty, full, half}, {9'h0A2, 3'b000});
        cycle(1'b1, 1'b0, 1'b1, '0);
        check("R8 rewind drops read", {dout, empty, full, half}, {9'h0A2, 3'b000});
        cycle(1'b1, 1'b0, 1'b0, '0);
        check("R8 first word again", {dout, empty, full, half}, {9'h0A1, 3'b000});
        cycle(1'b1, 1'b0, 1'b0, '0);
        cycle(1'b1, 1'b0, 1'b0, '0);
        check("R8 replay to end", {dout, empty, full, half}, {9'h0A3, 3'b100});

        // R8 rewind after a full pass brings the store back to full
        do_reset();
        for (int k = 0; k < DEPTH; k++) cycle(1'b0, 1'b1, 1'b0, 9'h0C0 + 9'(k));
        check("R3 full at depth", {dout, empty, full, half}, {9'h000, 3'b011});
        for (int k = 0; k < DEPTH; k++) cycle(1'b1, 1'b0, 1'b0, '0);
        check("R9 empty after wrap", {dout, empty, full, half}, {9'h0C7, 3'b100});
        cycle(1'b1, 1'b1, 1'b1, '0);
        check("R8 rewind refills", {dout, empty, full, half}, {9'h0C7, 3'b011});
        cycle(1'b0, 1'b1, 1'b0, 9'h1EE);
        check("R5 write dropped when full", {dout, empty, full, half}, {9'h0C7, 3'b011});
        cycle(1'b1, 1'b0, 1'b0, '0);
        check("R8 replay first", {dout, empty, full, half}, {9'h0C0, 3'b001});

        // R1 reset in the middle of traffic
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-run", {dout, empty, full, half}, {9'h000, 3'b100});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule